// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

A clocked monostable pulse generator. A programmable cycle count takes the place of an analog timing network. An output pulse can start from either edge of an external signal. A rising edge on one trigger input starts a pulse, and so does a falling edge on a second trigger input. Each trigger input is qualified by the level of the other input. An active-low clear ends a running pulse and holds off new pulses while it stays low. A mode input chooses one of two behaviours. In retriggerable mode, each new trigger pushes the end of the pulse out to a full period after that trigger. In one-pulse mode, triggers that arrive during a pulse are ignored.

All four control inputs are asynchronous to the clock. Each one passes through a two-flop synchroniser before any edge is detected. An input change therefore reaches the output after a fixed three rising clock edges. This latency is the same for every programmed period. The block drives a true output and a complementary output. The period input is captured when a trigger is accepted, so it only needs to be stable near each trigger. Two copies can be placed side by side as independent channels.

Top module: `oneshot_timer`

## Requirements
- R1: With trailTrig high, a rising edge on leadTrig starts a pulse. pulseOut is high for exactly periodCycles clock cycles. It rises after the third rising clock edge that follows the input change, and this latency does not depend on the period.
- R2: With leadTrig low, a falling edge on trailTrig starts a pulse with the same width and latency as in R1.
- R3: A rising edge on leadTrig is ignored while trailTrig is low. A falling edge on trailTrig is ignored while leadTrig is high.
- R4: With retrigMode = 1, an accepted trigger during a pulse reloads the count. The pulse then ends periodCycles cycles after the most recent trigger.
- R5: With retrigMode = 0, triggers that arrive while pulseOut is high are ignored. The pulse lasts periodCycles cycles from the first trigger.
- R6: When clearN goes low, pulseOut falls three clock edges later, whether or not a pulse is running. No pulse starts while clearN is low.
- R7: A trigger edge that reaches the synchronised domain in the same cycle as the release of clearN is ignored.
- R8: Two triggers in consecutive cycles are both honoured. The minimum retrigger interval is zero.
- R9: A trigger that arrives while periodCycles is zero is ignored, and no pulse is produced.
- R10: periodCycles is captured when a trigger is accepted. Changing it later does not alter the running pulse.
- R11: pulseOutN is always the inverse of pulseOut. After reset, pulseOut is low and pulseOutN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| leadTrig | input | 1 | Rising-edge trigger, asynchronous |
| trailTrig | input | 1 | Falling-edge trigger, asynchronous |
| clearN | input | 1 | Active-low pulse clear and inhibit, asynchronous |
| retrigMode | input | 1 | 1 = retriggerable, 0 = one pulse per period |
| periodCycles | input | PERIOD_W | Pulse length in clock cycles, 0 = no pulse |
| pulseOut | output | 1 | True pulse output |
| pulseOutN | output | 1 | Complementary pulse output |

## Verification
The bench checks every output edge against the cycle count the requirements predict. A latency that is off by one register, or a width that is off by one count, is caught directly. Two triggers are sent in adjacent cycles. A design that drops the second trigger ends its pulse one cycle early, and one that ignores the mode stretches a one-pulse-mode output. A trigger is sent with its cross input at the blocking level, and another with clear and trigger released together. A design that leaks either one produces a pulse where none should appear. A zero period and a period changed in mid-pulse expose a design that loads a dead count or keeps tracking the period input.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clr;   // force count to zero
    logic load;  // capture period into count
    logic dec;   // count down by one
  } osStrobe_t;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= RST_VAL;
          else        stageQ[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= RST_VAL;
          else        stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      leadS,
  input  logic      trailS,
  input  logic      clrS,
  input  logic      retrigS,
  input  logic      periodZero,
  input  logic      busy,
  output osStrobe_t strobe
);

  logic leadPrev, trailPrev, clrPrev;
  logic leadHit, trailHit, clrOpen, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leadPrev  <= 1'b0;
      trailPrev <= 1'b1;
      clrPrev   <= 1'b0;
    end else begin
      leadPrev  <= leadS;
      trailPrev <= trailS;
      clrPrev   <= clrS;
    end
  end

  always_comb begin
    // each edge is gated by the level of the other trigger input
    leadHit  = leadS & ~leadPrev & trailS;
    trailHit = trailPrev & ~trailS & ~leadS;
    // clear must be high now and in the previous cycle
    clrOpen  = clrS & clrPrev;
    fire     = (leadHit | trailHit) & clrOpen & ~periodZero & (retrigS | ~busy);
    strobe.clr  = ~clrS;
    strobe.load = fire;
    strobe.dec  = busy & ~fire & clrS;
  end

  // R5: no reload while a pulse runs in one-pulse mode
  a_r5_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !retrigS) |-> !strobe.load);

  // R6: clear held low blocks any load
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clrS |-> !strobe.load);

  // R7: cycle of clear release accepts nothing
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (clrS && !clrPrev) |-> !strobe.load);

  // R9: zero period is never loaded
  a_r9_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    periodZero |-> !strobe.load);

endmodule

// File: rtl/oneshot_dp.sv
module oneshot_dp
  import oneshot_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  osStrobe_t           strobe,
  input  logic [PERIOD_W-1:0] period,
  output logic                busy,
  output logic                qOut,
  output logic                qnOut
);

  logic [PERIOD_W-1:0] cnt, cntNext;
  logic qReg, qnReg;

  always_comb begin
    if (strobe.clr)       cntNext = '0;
    else if (strobe.load) cntNext = period;
    else if (strobe.dec)  cntNext = cnt - 1'b1;
    else                  cntNext = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      qReg  <= 1'b0;
      qnReg <= 1'b1;
    end else begin
      cnt   <= cntNext;
      qReg  <= (cntNext != '0);
      qnReg <= (cntNext == '0);
    end
  end

  assign busy  = qReg;
  assign qOut  = qReg;
  assign qnOut = qnReg;

  // R11: complementary outputs never agree
  a_r11_complement: assert property (@(posedge clk) disable iff (!rst_n)
    qReg != qnReg);

  // R6: clear empties the counter on the next edge
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clr |=> (cnt == '0) && !qReg);

  // R4: a load captures the period presented with it
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> cnt == $past(period));

  // R1: running pulse counts down by one per cycle
  a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dec |=> cnt == PERIOD_W'($past(cnt) - 1'b1));

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                leadTrig,
  input  logic                trailTrig,
  input  logic                clearN,
  input  logic                retrigMode,
  input  logic [PERIOD_W-1:0] periodCycles,
  output logic                pulseOut,
  output logic                pulseOutN
);

  localparam int N_ASYNC = 4;
  // bit order: mode, clear, trail, lead
  localparam logic [N_ASYNC-1:0] SYNC_RST = 4'b1010;

  logic [N_ASYNC-1:0] rawIn, syncOut;
  osStrobe_t strobe;
  logic busy;

  assign rawIn = {retrigMode, clearN, trailTrig, leadTrig};

  oneshot_sync #(
    .WIDTH(N_ASYNC),
    .STAGES(SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) sync_i (
    .clk(clk),
    .rst_n(rst_n),
    .din(rawIn),
    .dout(syncOut)
  );

  oneshot_ctrl ctrl_i (
    .clk(clk),
    .rst_n(rst_n),
    .leadS(syncOut[0]),
    .trailS(syncOut[1]),
    .clrS(syncOut[2]),
    .retrigS(syncOut[3]),
    .periodZero(periodCycles == '0),
    .busy(busy),
    .strobe(strobe)
  );

  oneshot_dp #(.PERIOD_W(PERIOD_W)) dp_i (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe),
    .period(periodCycles),
    .busy(busy),
    .qOut(pulseOut),
    .qnOut(pulseOutN)
  );

endmodule

// File: tb/oneshot_timer_tb_top.sv
`timescale 1ns/1ps
module oneshot_timer_tb_top;

  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic leadTrig = 1'b0;
  logic trailTrig = 1'b1;
  logic clearN = 1'b1;
  logic retrigMode = 1'b1;
  logic [PW-1:0] periodCycles = 16'd5;
  logic pulseOut, pulseOutN;

  int nChecks = 0;
  int nFails = 0;
  int offs = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  oneshot_timer #(.PERIOD_W(PW)) dut_i (
    .clk(clk),
    .rst_n(rst_n),
    .leadTrig(leadTrig),
    .trailTrig(trailTrig),
    .clearN(clearN),
    .retrigMode(retrigMode),
    .periodCycles(periodCycles),
    .pulseOut(pulseOut),
    .pulseOutN(pulseOutN)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    offs++;
  endtask

  task automatic checkOut(string tag, logic expHigh);
    nChecks++;
    if (pulseOut !== expHigh || pulseOutN !== ~expHigh) begin
      nFails++;
      $display("FAIL %s offset %0d: actual q=%b qn=%b expected q=%b qn=%b",
               tag, offs, pulseOut, pulseOutN, expHigh, ~expHigh);
    end
  endtask

  // Step to offset lastOff; output expected high on offsets hiFrom..hiTo
  task automatic watch(string tag, int lastOff, int hiFrom, int hiTo);
    while (offs < lastOff) begin
      tick();
      checkOut(tag, (offs >= hiFrom) && (offs <= hiTo));
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    offs = 0;
  endtask

  task automatic tResetState();
    checkOut("R11 reset", 1'b0);
  endtask

  task automatic tLeadEdge();
    periodCycles = 16'd5; settle(4);
    leadTrig = 1'b1;                      // R1
    watch("R1 lead edge", 10, 3, 7);
    leadTrig = 1'b0; settle(4);
    periodCycles = 16'd1;
    leadTrig = 1'b1;                      // R1 short period, same latency
    watch("R1 period one", 6, 3, 3);
    leadTrig = 1'b0; settle(4);
    periodCycles = 16'd40;
    leadTrig = 1'b1;                      // R1 long period, same latency
    watch("R1 period forty", 46, 3, 42);
    leadTrig = 1'b0; periodCycles = 16'd5; settle(4);
  endtask

  task automatic tTrailEdge();
    trailTrig = 1'b0;                     // R2
    watch("R2 trail edge", 10, 3, 7);
    trailTrig = 1'b1; settle(6);
  endtask

  task automatic tCrossGate();
    leadTrig = 1'b1;
    watch("R3 setup lead", 10, 3, 7);
    offs = 0;
    trailTrig = 1'b0;                     // blocked: lead high
    watch("R3 trail blocked", 10, 99, 0);
    leadTrig = 1'b0; settle(4);
    leadTrig = 1'b1;                      // blocked: trail low
    watch("R3 lead blocked", 10, 99, 0);
    leadTrig = 1'b0; settle(3);
    trailTrig = 1'b1; settle(6);
  endtask

  task automatic tRetrig();
    retrigMode = 1'b1; settle(4);
    leadTrig = 1'b1;
    tick(); tick();
    leadTrig = 1'b0; trailTrig = 1'b0;    // second trigger at offset 2
    watch("R4 retrigger", 13, 3, 9);
    trailTrig = 1'b1; settle(6);
  endtask

  task automatic tBackToBack();
    retrigMode = 1'b1; settle(4);
    leadTrig = 1'b1;
    tick();
    leadTrig = 1'b0; trailTrig = 1'b0;    // trigger in next cycle
    watch("R8 adjacent triggers", 12, 3, 8);
    trailTrig = 1'b1; settle(6);
  endtask

  task automatic tOnePulse();
    retrigMode = 1'b0; settle(4);
    leadTrig = 1'b1;
    tick(); tick();
    leadTrig = 1'b0; trailTrig = 1'b0;
    watch("R5 one-pulse ignore", 12, 3, 7);
    trailTrig = 1'b1; settle(6);
    leadTrig = 1'b1;                      // accepted again once idle
    watch("R5 after pulse", 10, 3, 7);
    leadTrig = 1'b0; retrigMode = 1'b1; settle(6);
  endtask

  task automatic tClear();
    periodCycles = 16'd20; settle(2);
    leadTrig = 1'b1;
    tick(); tick(); tick(); tick(); tick();
    clearN = 1'b0;                        // at offset 5
    watch("R6 clear mid-pulse", 14, 3, 7);
    leadTrig = 1'b0; settle(4);
    leadTrig = 1'b1;
    watch("R6 trigger while clear", 10, 99, 0);
    leadTrig = 1'b0; settle(4);
    periodCycles = 16'd3;
    clearN = 1'b1; leadTrig = 1'b1;       // release with trigger
    watch("R7 release same cycle", 10, 99, 0);
    leadTrig = 1'b0; settle(4);
    leadTrig = 1'b1;
    watch("R7 after release", 8, 3, 5);
    leadTrig = 1'b0; periodCycles = 16'd5; settle(6);
  endtask

  task automatic tZeroPeriod();
    periodCycles = 16'd0; settle(2);
    leadTrig = 1'b1;
    watch("R9 zero period", 10, 99, 0);
    leadTrig = 1'b0; periodCycles = 16'd5; settle(6);
  endtask

  task automatic tPeriodCapture();
    periodCycles = 16'd5; settle(2);
    leadTrig = 1'b1;
    tick(); tick(); tick(); tick();
    periodCycles = 16'd12;                // changed after capture
    watch("R10 period captured", 12, 3, 7);
    leadTrig = 1'b0; periodCycles = 16'd5; settle(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rst_n = 1'b1;
    settle(4);
    tResetState();
    tLeadEdge();
    tTrailEdge();
    tCrossGate();
    tRetrig();
    tBackToBack();
    tOnePulse();
    tClear();
    tZeroPeriod();
    tPeriodCapture();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule